// File: doc/BRIEF.md
# Two-Wire Control Register Slave for a Clock Generator

This block is the serial configuration port of a clock generator. It listens on a two-wire bus (SCL and SDA), answers one of four device addresses picked by two strap inputs, and maintains a bank of eight 8-bit control registers. Their contents leave the block as one flat parallel bus that feeds the output enables, spread and frequency selects of the clock generator. The pins are oversampled in a fast system clock domain. SDA is driven open-drain: the block only ever pulls the line low, through an output-enable.

Each write phase carries a command byte. When its top bit is set, the transfer is a single-byte access, and the low seven bits give the register offset. When its top bit is clear, the transfer is a block access. A block write sends a byte count and then data that fills the registers from offset 0 upward. A block read, issued after a repeated start, returns a byte count of 8 and then the registers in ascending order until the master answers with NACK. The registers take fixed power-up values when reset is applied.

Top module: `clkgen_twi_regs`

## Requirements
- R1: The device address in the upper seven bits of the first byte after a start is 7'b1101_0, followed by `addr_sel[1:0]`. This gives 8-bit addresses D0h, D2h, D4h and D6h for `addr_sel` = 0, 1, 2 and 3. A matching address is acknowledged by pulling SDA low in the ninth clock.
- R2: An address that does not match is not acknowledged. The block then ignores the bus, and acknowledges nothing, until the next start condition.
- R3: After reset `sda_oe` is 0, and register i appears on `reg_bus[8*i+7:8*i]` with these values: registers 0 and 1 hold FFh, register 2 holds 04h, registers 3 to 6 hold 00h, and register 7 holds 95h.
- R4: A byte write (address with R/W bit 0, command 1ooooooo, one data byte) loads the data into register `ooooooo`. Every byte is acknowledged and no other register changes.
- R5: A byte read returns the register at the offset held in the last command. The sequence is: command 1ooooooo in a write phase, repeated start, address with R/W bit 1.
- R6: A write to offset 8 or above is acknowledged and changes no register. A read from offset 8 or above returns 00h.
- R7: A block write (command 00h) acknowledges a count byte, whose value is not used. It then writes the following data bytes to registers 0, 1, 2 and upward, and acknowledges each one.
- R8: A block write that ends with a stop after k complete data bytes changes only registers 0 to k-1.
- R9: A block read (command 00h, repeated start, read address) returns the count byte 08h first. It then returns registers 0 to 7 in order. A NACK from the master ends the transmission, and the block releases SDA.
- R10: Bits travel most significant bit first in both directions. The block changes `sda_oe` only after a falling edge of SCL, except to release the line on a start or a stop.
- R11: A start or stop condition, recognised as an SDA edge while SCL is high, cancels any partly received byte without writing it. After a start, the block expects an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus pins |
| rst | input | 1 | Synchronous active-high reset, loads the power-up values |
| scl_pin | input | 1 | Bus clock line as seen at the pin |
| sda_pin | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 2 | Strap inputs selecting one of four device addresses |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| reg_bus | output | 64 | Register contents, register i in bits 8*i+7 to 8*i |

## Verification
A wrong pointer or role in the block becomes visible on the data bus within one byte time. Either a read returns a value from the wrong offset, or the wrong field of `reg_bus` changes after a write. A wrong protocol state appears at the ports as a missing or extra acknowledge in the ninth clock of the same byte. A partial byte committed on a stop appears as soon as the stop is over. Because of this, the bench checks every acknowledge bit and compares the whole register bus after every transaction.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_WAIT,
        ST_ACK,
        ST_TX,
        ST_TX_WAIT,
        ST_TX_ACK,
        ST_TX_NEXT
    } twi_state_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_COUNT,
        RL_DATA
    } twi_role_e;

    typedef struct packed {
        logic             single;
        logic [IDX_W-1:0] offset;
    } twi_cmd_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [6:0] dev_addr(input logic [1:0] sel);
        return {4'b1101, 1'b0, sel};
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0, 1:    return 8'hFF;
            2:       return 8'h04;
            7:       return 8'h95;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync
    import twi_regs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_pin,
    input  logic     sda_pin,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
            sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_now = scl_ff[STAGES-1];
    assign sda_now = sda_ff[STAGES-1];

    always_comb begin
        evt.scl      = scl_now;
        evt.sda      = sda_now;
        evt.scl_rise = scl_now & ~scl_q;
        evt.scl_fall = ~scl_now & scl_q;
        evt.start    = scl_now & scl_q & sda_q & ~sda_now;
        evt.stop     = scl_now & scl_q & ~sda_q & sda_now;
    end

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
    import twi_regs_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NREG*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] regs [NREG];
    logic              in_range;

    assign in_range = (idx < IDX_W'(NREG));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= reg_default(g);
            end else if (wr_en && idx == IDX_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (in_range && idx == IDX_W'(i)) rd_data = regs[i];
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (idx < IDX_W'(NREG))); // R6

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(regs_flat)); // R4

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_regs_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam logic [BYTE_W-1:0] BLOCK_COUNT = BYTE_W'(NREG);

    twi_state_e        state;
    twi_role_e         role;
    twi_cmd_t          cmd;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              count_pend;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] tx_byte;
    logic              addr_hit;
    twi_cmd_t          rx_cmd;

    assign tx_byte  = count_pend ? BLOCK_COUNT : rd_data;
    assign addr_hit = (shreg[7:1] == dev_addr(addr_sel));
    assign rx_cmd   = twi_cmd_t'(shreg);
    assign idx      = ptr;
    assign wr_data  = shreg;
    assign wr_en    = (state == ST_RX_WAIT) && evt.scl_fall && (role == RL_DATA)
                      && (ptr < IDX_W'(NREG));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            role       <= RL_ADDR;
            cmd        <= '0;
            bitcnt     <= '0;
            shreg      <= '0;
            rw         <= 1'b0;
            count_pend <= 1'b0;
            ptr        <= '0;
            sda_oe     <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_RX;
            role   <= RL_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (evt.scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) state <= ST_RX_WAIT;
                    end
                end
                ST_RX_WAIT: begin
                    if (evt.scl_fall) begin
                        case (role)
                            RL_ADDR: begin
                                if (addr_hit) begin
                                    sda_oe     <= 1'b1;
                                    rw         <= shreg[0];
                                    state      <= ST_ACK;
                                    ptr        <= cmd.single ? cmd.offset : '0;
                                    count_pend <= ~cmd.single;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            RL_CMD: begin
                                cmd    <= rx_cmd;
                                ptr    <= rx_cmd.single ? rx_cmd.offset : '0;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                            RL_COUNT: begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                            default: begin
                                sda_oe <= 1'b1;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (evt.scl_fall) begin
                        bitcnt <= '0;
                        if (role == RL_ADDR && rw) begin
                            shreg  <= {tx_byte[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_byte[BYTE_W-1];
                            state  <= ST_TX;
                            if (count_pend) count_pend <= 1'b0;
                            else            ptr        <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                            case (role)
                                RL_ADDR: role <= RL_CMD;
                                RL_CMD:  role <= cmd.single ? RL_DATA : RL_COUNT;
                                default: role <= RL_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (evt.scl_rise) begin
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) state <= ST_TX_WAIT;
                    end else if (evt.scl_fall) begin
                        sda_oe <= ~shreg[BYTE_W-1];
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_TX_WAIT: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TX_ACK;
                    end
                end
                ST_TX_ACK: begin
                    if (evt.scl_rise) state <= evt.sda ? ST_IDLE : ST_TX_NEXT;
                end
                ST_TX_NEXT: begin
                    if (evt.scl_fall) begin
                        bitcnt <= '0;
                        shreg  <= {tx_byte[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_byte[BYTE_W-1];
                        state  <= ST_TX;
                        if (count_pend) count_pend <= 1'b0;
                        else            ptr        <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(evt.scl_fall)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R2

    AST_START_RESYNC: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_RX && role == RL_ADDR && !sda_oe)); // R11

    AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX) |-> rw); // R5

endmodule

// File: rtl/clkgen_twi_regs.sv
module clkgen_twi_regs
    import twi_regs_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_pin,
    input  logic                   sda_pin,
    input  logic [1:0]             addr_sel,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] reg_bus
);

    bus_evt_t          evt;
    logic              wr_en;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    twi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_pin (scl_pin),
        .sda_pin (sda_pin),
        .evt     (evt)
    );

    twi_slave_fsm #(.NREG(NREG)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .idx      (idx),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    twi_regbank #(.NREG(NREG)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .idx       (idx),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .regs_flat (reg_bus)
    );

endmodule

// File: tb/test_clkgen_twi_regs.sv
module test_clkgen_twi_regs;

    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'd0;
    logic        sda_oe;
    logic [63:0] reg_bus;
    logic        sda_line;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [7:0]  model [8];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    clkgen_twi_regs i_clkgen_twi_regs (
        .clk      (clk),
        .rst      (rst),
        .scl_pin  (scl),
        .sda_pin  (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .reg_bus  (reg_bus)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        tick(Q); sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    endtask

    task automatic recv_bit(output bit b);
        tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic rd_byte(output logic [7:0] d, input bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < 8; i++) check(req, int'(reg_bus[i*8 +: 8]), int'(model[i]));
    endtask

    function automatic logic [7:0] pattern(input int i, input int s);
        return 8'((i * 37 + s * 11 + 8'h5A) & 8'hFF);
    endfunction

    task automatic byte_write(input logic [6:0] off, input logic [7:0] v, input string req);
        bit a;
        bus_start();
        wr_byte(8'hD4, a); check(req, int'(a), 1);
        wr_byte({1'b1, off}, a); check(req, int'(a), 1);
        wr_byte(v, a); check(req, int'(a), 1);
        bus_stop();
        if (off < 7'd8) model[off[2:0]] = v;
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] v);
        bit a;
        bus_start();
        wr_byte(8'hD4, a);
        wr_byte({1'b1, off}, a);
        bus_start();
        wr_byte(8'hD5, a);
        rd_byte(v, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic [7:0] v;
        bit a;
        for (int i = 0; i < 8; i++)
            model[i] = (i < 2) ? 8'hFF : (i == 2) ? 8'h04 : (i == 7) ? 8'h95 : 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R3: power-up values and released line
        check("R3", int'(sda_oe), 0);
        check_bank("R3");

        // R1 / R2: every strap setting against every candidate address
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            for (int t = 0; t < 4; t++) begin
                bus_start();
                wr_byte(8'(8'hD0 + 2 * t), a);
                check((s == t) ? "R1" : "R2", int'(a), (s == t) ? 1 : 0);
                if (s != t) begin
                    wr_byte(8'h81, a);
                    check("R2", int'(a), 0);
                end
                bus_stop();
            end
        end
        check_bank("R2");
        addr_sel = 2'd2;

        // R4 / R5: byte write then byte read of every offset
        for (int i = 0; i < 8; i++) begin
            byte_write(7'(i), pattern(i, 1), "R4");
            check_bank("R4");
        end
        for (int i = 0; i < 8; i++) begin
            byte_read(7'(i), v);
            check("R5", int'(v), int'(model[i]));
        end

        // R10: bit order
        byte_write(7'd5, 8'h01, "R10");
        check("R10", int'(reg_bus[5*8 +: 8]), 1);
        byte_read(7'd5, v);
        check("R10", int'(v), 1);

        // R6: offsets beyond the bank
        byte_write(7'd9, 8'hAA, "R6");
        byte_write(7'd127, 8'h55, "R6");
        check_bank("R6");
        byte_read(7'd9, v);
        check("R6", int'(v), 0);

        // R7: full block write
        bus_start();
        wr_byte(8'hD4, a); check("R7", int'(a), 1);
        wr_byte(8'h00, a); check("R7", int'(a), 1);
        wr_byte(8'h08, a); check("R7", int'(a), 1);
        for (int i = 0; i < 8; i++) begin
            wr_byte(pattern(i, 2), a);
            check("R7", int'(a), 1);
            model[i] = pattern(i, 2);
        end
        bus_stop();
        check_bank("R7");

        // R8: block write cut short after three bytes
        bus_start();
        wr_byte(8'hD4, a);
        wr_byte(8'h00, a);
        wr_byte(8'h08, a);
        for (int i = 0; i < 3; i++) begin
            wr_byte(pattern(i, 3), a);
            check("R8", int'(a), 1);
            model[i] = pattern(i, 3);
        end
        bus_stop();
        check_bank("R8");

        // R9: block read returns count then registers
        bus_start();
        wr_byte(8'hD4, a);
        wr_byte(8'h00, a);
        bus_start();
        wr_byte(8'hD5, a); check("R9", int'(a), 1);
        rd_byte(v, 1'b1);
        check("R9", int'(v), 8);
        for (int i = 0; i < 8; i++) begin
            rd_byte(v, i < 7);
            check("R9", int'(v), int'(model[i]));
        end
        check("R9", int'(sda_oe), 0);
        bus_stop();

        // R11: stop in the middle of a data byte
        bus_start();
        wr_byte(8'hD4, a);
        wr_byte(8'h83, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check_bank("R11");
        byte_read(7'd3, v);
        check("R11", int'(v), int'(model[3]));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule